// File: doc/BRIEF.md
# Dual-Slot Boot Supervisor

This block is the control core of a resident recovery configuration on a board whose configuration flash holds two image slots. Slot 0 holds the recovery image and slot 1 holds the user image. After reset the block qualifies an external jumper. With the jumper open it issues one reconfiguration request aimed at the start of the user slot. With the jumper fitted it stays resident, so the board can always be reflashed over the host link.

While resident, the block decides which flash writes are permitted. The recovery slot is locked until software sets an unlock bit. The user slot is always writable. A self-test bit makes the normally tristated expansion pins carry a free-running counter, so a probe can check board assembly. A heartbeat LED blinks at 1 Hz. The flash serial protocol and the reconfiguration primitive sit outside the block.

Top module: `boot_supervisor`

## Requirements
- R1: `jumper_i` passes through a two-flop synchronizer. The boot decision is taken only after `STABLE_N` (default 16) consecutive equal synchronized samples. Any change restarts the count.
- R2: If the qualified jumper level is 0 (open), `reconf_req_o` pulses high for exactly one cycle. From that cycle on, `reconf_addr_o` holds 1 × `SLOT_SIZE`. Before that it reads 0.
- R3: If the qualified jumper level is 1 (fitted), no request is ever issued and status bit 1 stays 0.
- R4: The decision is taken once per reset. Later jumper changes never cause another request.
- R5: A flash write request whose address is below `SLOT_SIZE` (slot 0) is allowed only while control bit 1 (unlock) is set.
- R6: A request in [`SLOT_SIZE`, 2×`SLOT_SIZE`) (slot 1) is always allowed. Addresses at or above 2×`SLOT_SIZE` are never allowed. With no request, `flash_wr_allow_o` is 0.
- R7: With control bit 0 (self-test) set, `exp_oe_o` is all ones and `exp_out_o` shows an 8-bit counter. The counter runs from reset and steps every `CLK_HZ/ST_TICK_HZ` cycles. With the bit clear, both outputs are 0.
- R8: `led_o` is 0 after reset and toggles every `CLK_HZ/2` cycles.
- R9: Register address 0 is control, with bits [1:0] read/write and the upper bits reading 0. Address 1 is read-only status: bit 0 is the synchronized jumper and bit 1 is a sticky "request issued" flag. Other addresses read 0, and writes to them are ignored. Reads are combinational.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| jumper_i | input | 1 | Boot jumper, 1 = fitted |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| flash_wr_req_i | input | 1 | Flash write request |
| flash_wr_addr_i | input | FADDR_W | Flash write byte address |
| flash_wr_allow_o | output | 1 | Write permitted |
| reconf_req_o | output | 1 | Reconfiguration request pulse |
| reconf_addr_o | output | FADDR_W | Start address of target image |
| exp_out_o | output | PIN_W | Expansion pin drive value |
| exp_oe_o | output | PIN_W | Expansion pin output enable |
| led_o | output | 1 | Heartbeat LED |

## Verification
A wrong qualifier count or reference level shows up directly at the request pulse. The pulse moves by a cycle or more, or appears when the jumper is fitted. A leaked second pulse shows whenever the jumper moves after the decision. A fault in the lock logic shows in the same cycle as a request into slot 0. A divider fault in the heartbeat or self-test counter shows within one period as a mis-timed LED edge or pin step. The bench compares every output against a behavioural model on every cycle, so each of these is seen the cycle it occurs.

// File: rtl/boot_sup_pkg.sv
package boot_sup_pkg;
  typedef struct packed {
    logic unlock;
    logic st_en;
  } ctrl_t;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned USER_SLOT = 1;
  localparam logic        JMP_FITTED = 1'b1;
endpackage

// File: rtl/boot_jumper_qual.sv
module boot_jumper_qual #(
  parameter int unsigned STABLE_N = 16,
  parameter int unsigned FADDR_W  = 24,
  parameter logic [FADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               jumper_i,
  output logic               jmp_sync_o,
  output logic               reconf_req_o,
  output logic [FADDR_W-1:0] reconf_addr_o,
  output logic               requested_o
);
  import boot_sup_pkg::*;

  localparam int unsigned Q_W = $clog2(STABLE_N + 1);

  logic           s1_q, s2_q, ref_q, dec_q;
  logic [Q_W-1:0] cnt_q;

  assign jmp_sync_o = s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q          <= 1'b0;
      s2_q          <= 1'b0;
      ref_q         <= 1'b0;
      dec_q         <= 1'b0;
      cnt_q         <= '0;
      reconf_req_o  <= 1'b0;
      reconf_addr_o <= '0;
      requested_o   <= 1'b0;
    end else begin
      s1_q         <= jumper_i;
      s2_q         <= s1_q;
      reconf_req_o <= 1'b0;
      if (!dec_q) begin
        if (cnt_q == Q_W'(STABLE_N)) begin
          dec_q <= 1'b1;
          if (ref_q != JMP_FITTED) begin
            reconf_req_o  <= 1'b1;
            reconf_addr_o <= BOOT_ADDR;
            requested_o   <= 1'b1;
          end
        end else if (cnt_q != '0 && s2_q == ref_q) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          ref_q <= s2_q;
          cnt_q <= Q_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/boot_flash_guard.sv
module boot_flash_guard #(
  parameter int unsigned FADDR_W   = 24,
  parameter int unsigned SLOT_SIZE = 24'h080000
) (
  input  logic               req_i,
  input  logic [FADDR_W-1:0] addr_i,
  input  logic               unlock_i,
  output logic               allow_o
);
  localparam logic [FADDR_W:0] SLOT1_LO = (FADDR_W+1)'(SLOT_SIZE);
  localparam logic [FADDR_W:0] SLOT1_HI = (FADDR_W+1)'(2 * SLOT_SIZE);

  logic in_slot0, in_slot1;

  assign in_slot0 = {1'b0, addr_i} < SLOT1_LO;
  assign in_slot1 = !in_slot0 && ({1'b0, addr_i} < SLOT1_HI);
  assign allow_o  = req_i && ((in_slot0 && unlock_i) || in_slot1);
endmodule

// File: rtl/boot_heartbeat.sv
module boot_heartbeat #(
  parameter int unsigned CLK_HZ = 40_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic led_o
);
  localparam int unsigned HALF = (CLK_HZ / 2 > 1) ? CLK_HZ / 2 : 1;
  localparam int unsigned HB_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HB_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      led_o <= 1'b0;
    end else if (div_q == HB_W'(HALF - 1)) begin
      div_q <= '0;
      led_o <= ~led_o;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_selftest.sv
module boot_selftest #(
  parameter int unsigned CLK_HZ     = 40_000_000,
  parameter int unsigned ST_TICK_HZ = 1_000_000,
  parameter int unsigned PIN_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [PIN_W-1:0] exp_out_o,
  output logic [PIN_W-1:0] exp_oe_o
);
  localparam int unsigned DIV   = (CLK_HZ / ST_TICK_HZ > 1) ? CLK_HZ / ST_TICK_HZ : 1;
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == PRE_W'(DIV - 1)) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign exp_oe_o[i]  = en_i;
    assign exp_out_o[i] = en_i & cnt_q[i];
  end
endmodule

// File: rtl/boot_supervisor.sv
module boot_supervisor #(
  parameter int unsigned CLK_HZ     = 40_000_000,
  parameter int unsigned ST_TICK_HZ = 1_000_000,
  parameter int unsigned STABLE_N   = 16,
  parameter int unsigned FADDR_W    = 24,
  parameter int unsigned SLOT_SIZE  = 24'h080000,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PIN_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               jumper_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               flash_wr_req_i,
  input  logic [FADDR_W-1:0] flash_wr_addr_i,
  output logic               flash_wr_allow_o,
  output logic               reconf_req_o,
  output logic [FADDR_W-1:0] reconf_addr_o,
  output logic [PIN_W-1:0]   exp_out_o,
  output logic [PIN_W-1:0]   exp_oe_o,
  output logic               led_o
);
  import boot_sup_pkg::*;

  localparam logic [FADDR_W-1:0] USER_ADDR = FADDR_W'(USER_SLOT * SLOT_SIZE);

  ctrl_t ctrl_q;
  logic  jmp_sync, requested;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_W'(REG_CTRL))
      ctrl_q <= ctrl_t'(reg_wdata_i[1:0]);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(REG_CTRL)) reg_rdata_o[1:0] = ctrl_q;
    else if (reg_addr_i == ADDR_W'(REG_STAT)) reg_rdata_o[1:0] = {requested, jmp_sync};
  end

  boot_jumper_qual #(
    .STABLE_N (STABLE_N),
    .FADDR_W  (FADDR_W),
    .BOOT_ADDR(USER_ADDR)
  ) u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .jumper_i     (jumper_i),
    .jmp_sync_o   (jmp_sync),
    .reconf_req_o (reconf_req_o),
    .reconf_addr_o(reconf_addr_o),
    .requested_o  (requested)
  );

  boot_flash_guard #(
    .FADDR_W  (FADDR_W),
    .SLOT_SIZE(SLOT_SIZE)
  ) u_guard (
    .req_i   (flash_wr_req_i),
    .addr_i  (flash_wr_addr_i),
    .unlock_i(ctrl_q.unlock),
    .allow_o (flash_wr_allow_o)
  );

  boot_heartbeat #(.CLK_HZ(CLK_HZ)) u_hb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .led_o (led_o)
  );

  boot_selftest #(
    .CLK_HZ    (CLK_HZ),
    .ST_TICK_HZ(ST_TICK_HZ),
    .PIN_W     (PIN_W)
  ) u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.st_en),
    .exp_out_o(exp_out_o),
    .exp_oe_o (exp_oe_o)
  );
endmodule

// File: rtl/boot_supervisor_chk.sv
module boot_supervisor_chk #(
  parameter int unsigned FADDR_W   = 24,
  parameter int unsigned SLOT_SIZE = 24'h080000,
  parameter int unsigned PIN_W     = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reconf_req_i,
  input logic [FADDR_W-1:0] reconf_addr_i,
  input logic               wr_req_i,
  input logic [FADDR_W-1:0] wr_addr_i,
  input logic               wr_allow_i,
  input logic               unlock_i,
  input logic               st_en_i,
  input logic [PIN_W-1:0]   exp_out_i,
  input logic [PIN_W-1:0]   exp_oe_i
);
  localparam logic [FADDR_W:0] LO = (FADDR_W+1)'(SLOT_SIZE);
  localparam logic [FADDR_W:0] HI = (FADDR_W+1)'(2 * SLOT_SIZE);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (reconf_req_i) seen_q <= 1'b1;
  end

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconf_req_i |=> !reconf_req_i);

  assert_target_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconf_req_i |-> reconf_addr_i == FADDR_W'(SLOT_SIZE));

  assert_single_decision_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconf_req_i |-> !seen_q);

  assert_slot0_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_allow_i && ({1'b0, wr_addr_i} < LO)) |-> unlock_i);

  assert_slot1_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && ({1'b0, wr_addr_i} >= LO) && ({1'b0, wr_addr_i} < HI)) |-> wr_allow_i);

  assert_beyond_denied_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, wr_addr_i} >= HI) |-> !wr_allow_i);

  assert_pins_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_en_i |-> (exp_oe_i == '0 && exp_out_i == '0));

  assert_pins_driven_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_i |-> &exp_oe_i);

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_en_i && $past(st_en_i)) |->
      (exp_out_i == $past(exp_out_i) || exp_out_i == $past(exp_out_i) + 1'b1));
endmodule

bind boot_supervisor boot_supervisor_chk #(
  .FADDR_W  (FADDR_W),
  .SLOT_SIZE(SLOT_SIZE),
  .PIN_W    (PIN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reconf_req_i (reconf_req_o),
  .reconf_addr_i(reconf_addr_o),
  .wr_req_i     (flash_wr_req_i),
  .wr_addr_i    (flash_wr_addr_i),
  .wr_allow_i   (flash_wr_allow_o),
  .unlock_i     (ctrl_q.unlock),
  .st_en_i      (ctrl_q.st_en),
  .exp_out_i    (exp_out_o),
  .exp_oe_i     (exp_oe_o)
);

// File: tb/tb_boot_supervisor.sv
`timescale 1ns/100ps
module tb_boot_supervisor;
  localparam int CLK_HZ = 20;
  localparam int TICK   = 5;
  localparam int STABLE = 16;
  localparam int SLOT   = 24'h080000;
  localparam int HALF   = CLK_HZ / 2;
  localparam int DIV    = CLK_HZ / TICK;

  logic        clk = 0, rst_ni = 0, jumper = 0;
  logic        we = 0, fw_req = 0;
  logic [1:0]  raddr = 0;
  logic [7:0]  wdata = 0;
  logic [23:0] fw_addr = 0;
  logic [7:0]  rdata, eout, eoe;
  logic        allow, req, led;
  logic [23:0] raddr_o;

  int tests = 0, fails = 0, cycles = 0, pulses = 0;
  bit done = 0;

  // reference model state
  int m_s1, m_s2, m_ref, m_cnt, m_dec, m_req, m_addr, m_stk;
  int m_ctrl, m_hb, m_led, m_pre, m_st;

  boot_supervisor #(
    .CLK_HZ(CLK_HZ), .ST_TICK_HZ(TICK), .STABLE_N(STABLE),
    .FADDR_W(24), .SLOT_SIZE(SLOT), .ADDR_W(2), .DATA_W(8), .PIN_W(8)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .jumper_i(jumper),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .flash_wr_req_i(fw_req), .flash_wr_addr_i(fw_addr), .flash_wr_allow_o(allow),
    .reconf_req_o(req), .reconf_addr_o(raddr_o),
    .exp_out_o(eout), .exp_oe_o(eoe), .led_o(led)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_ref = 0; m_cnt = 0; m_dec = 0; m_req = 0;
    m_addr = 0; m_stk = 0; m_ctrl = 0; m_hb = 0; m_led = 0; m_pre = 0; m_st = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      int nreq;
      nreq = 0;
      if (!m_dec) begin
        if (m_cnt == STABLE) begin
          m_dec = 1;
          if (m_ref == 0) begin nreq = 1; m_addr = SLOT; m_stk = 1; end
        end else if (m_cnt != 0 && m_s2 == m_ref) m_cnt++;
        else begin m_ref = m_s2; m_cnt = 1; end
      end
      m_req = nreq;
      m_s2 = m_s1; m_s1 = int'(jumper);
      if (we && raddr == 0) m_ctrl = wdata & 3;
      if (m_hb == HALF - 1) begin m_hb = 0; m_led ^= 1; end else m_hb++;
      if (m_pre == DIV - 1) begin m_pre = 0; m_st = (m_st + 1) % 256; end else m_pre++;
    end
  end

  // per-cycle comparison, sampled mid-low-phase
  always @(negedge clk) begin
    #2;
    if (!done) begin
      int er, ea, eo;
      er = (raddr == 0) ? m_ctrl : (raddr == 1) ? ((m_stk << 1) | m_s2) : 0;
      ea = fw_req && (((fw_addr < SLOT) && (m_ctrl & 2) != 0) ||
                      (fw_addr >= SLOT && fw_addr < 2 * SLOT));
      eo = (m_ctrl & 1) ? m_st : 0;
      check(req == m_req,          "R1 R2 reconf_req", req, m_req);
      check(raddr_o == m_addr,     "R2 reconf_addr", raddr_o, m_addr);
      check(led == m_led,          "R8 led", led, m_led);
      check(eoe == ((m_ctrl & 1) ? 8'hFF : 8'h00), "R7 exp_oe", eoe, (m_ctrl & 1) ? 255 : 0);
      check(eout == eo,            "R7 exp_out", eout, eo);
      check(rdata == er,           "R9 rdata", rdata, er);
      check(allow == ea,           "R5 R6 allow", allow, ea);
      if (req) pulses++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1; raddr = a[1:0]; wdata = d[7:0];
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); raddr = a[1:0];
    #1 check(rdata == exp[7:0], tag, rdata, exp);
  endtask

  task automatic fw(input int a);
    @(negedge clk); fw_req = 1; fw_addr = a[23:0];
    @(negedge clk); fw_req = 0;
  endtask

  initial begin
    #1;
    check(req == 0 && led == 0 && eoe == 0 && eout == 0 && allow == 0 && raddr_o == 0,
          "R10 reset outputs", {req, led, allow}, 0);
    cyc(2); rst_ni = 1;

    // R1: glitchy jumper, then steady open
    jumper = 1; cyc(6); jumper = 0; cyc(3); jumper = 1; cyc(2);
    jumper = 0; cyc(30);
    check(pulses == 1, "R2 one request when open", pulses, 1);
    // R4: jumper moves after decision
    for (int i = 0; i < 8; i++) begin jumper = ~jumper; cyc(3); end
    check(pulses == 1, "R4 no further request", pulses, 1);
    jumper = 0;

    // R7 self-test
    wr(0, 1); cyc(40);
    // R5/R6 before unlock
    fw(5); fw(SLOT - 1); fw(SLOT + 3); fw(2 * SLOT - 1); fw(2 * SLOT);
    wr(0, 3); fw(5); fw(0); fw(2 * SLOT + 7);
    // R9 register map
    wr(0, 'hFF); rd(0, 3, "R9 ctrl upper bits");
    wr(2, 'h55); rd(2, 0, "R9 unmapped read");
    rd(0, 3, "R9 unmapped write ignored");
    wr(1, 0); rd(1, 2, "R9 status read-only");
    wr(0, 0); cyc(10); fw(5);

    // R3: fitted jumper after fresh reset
    @(negedge clk); rst_ni = 0; jumper = 1; pulses = 0;
    cyc(2); rst_ni = 1; cyc(40);
    check(pulses == 0, "R3 no request when fitted", pulses, 0);
    rd(1, 1, "R3 status fitted");
    cyc(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule